// File: doc/BRIEF.md
# Prescaled Variable-Resolution PWM Generator

This block produces one pulse-width-modulated line whose period is built from a chain of three counters. A clock-select code picks one of three slower source rates. Each rate arrives as a single-cycle enable on the system clock. A prescaler divides the chosen rate by 2, 3, 5 or 6. A second stage divides again by 2^m, with m from 0 to 7. A resolution counter of 6 or 9 bits then sets the number of steps in one period. The output period is therefore source period × N × D × 2^m, where N is 64 or 512.

The duty value is 9 bits wide and arrives as an 8-bit low field plus a separate top bit. In 6-bit mode only bits 5..0 count. The line is high while the resolution counter is below the captured duty value. A new duty value is captured only at the end of a period or while the channel is idle, so a change cannot produce a runt pulse. The channel runs only when both enable bits are set and a source is selected. Otherwise every counter is cleared and the line is low. The next start always begins at count zero.

Top module: `pwmgen_top`

## Requirements
- R1: The resolution counter advances by one after every D × 2^m ticks of the selected source, so one period lasts N × D × 2^m source ticks. The counter starts at zero when the channel is enabled.
- R2: Clock-select code 1 uses `tick_slow`, code 2 uses `tick_mid` and code 3 uses `tick_fast`. Ticks on the sources that are not selected have no effect.
- R3: Prescale code 0, 1, 2 and 3 gives a divisor D of 2, 3, 5 and 6.
- R4: The 3-bit exponent m multiplies the step time by 2^m, for m from 0 to 7.
- R5: `wide_mode`=1 selects N=512 and uses the duty value {`duty_msb`, `duty_lsbs`[7:0]}. `wide_mode`=0 selects N=64 and uses only `duty_lsbs`[5:0]. Duty bits 8..6 are then ignored.
- R6: `pwm_out` is high exactly while the resolution count is below the captured duty value. A duty of zero keeps the line low for the whole period.
- R7: A duty value presented while the channel runs takes effect only from the next period boundary. While the channel is idle, the duty value is captured continuously.
- R8: When `out_en` or `run_en` is low, `pwm_out` is low and all counters are cleared. Re-enabling restarts the period from count zero.
- R9: Clock-select code 0 stops the channel the same way as a cleared enable, and `pwm_out` stays low.
- R10: While `rst` is high, `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Single-cycle enable at the slowest source rate |
| tick_mid | input | 1 | Single-cycle enable at the middle source rate |
| tick_fast | input | 1 | Single-cycle enable at the fastest source rate |
| src_sel | input | 2 | Source code: 0 none, 1 slow, 2 mid, 3 fast |
| div_code | input | 2 | Prescale code: 0..3 selects divisor 2, 3, 5, 6 |
| exp_m | input | 3 | Power-of-two exponent m |
| wide_mode | input | 1 | 1 = 9-bit resolution, 0 = 6-bit resolution |
| duty_lsbs | input | 8 | Duty value bits 7..0 |
| duty_msb | input | 1 | Duty value bit 8, used in 9-bit mode only |
| out_en | input | 1 | Output enable; both enables are needed to run |
| run_en | input | 1 | Modulator enable; both enables are needed to run |
| pwm_out | output | 1 | Modulated output line |

## Verification
The assertions assume that the tick inputs are single-cycle enables sampled on the system clock. They also assume that the prescale code, exponent and size bit stay fixed while the channel runs. A change to any of these is expected only while the channel is idle. The bench follows this by changing the configuration only with both enables low, and it holds them low for two cycles before it re-enables. Only the duty value is changed during a run, which exercises the boundary capture. While one source is being measured, the sources that are not selected keep ticking on every cycle.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

    localparam int NUM_SRC  = 3;
    localparam int EXP_W    = 3;
    localparam int WIDE_W   = 9;
    localparam int NARROW_W = 6;
    localparam int DIV_W    = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_MID  = 2'd2,
        SRC_FAST = 2'd3
    } src_e;

    // Terminal count of the prescaler (divisor minus one).
    function automatic logic [DIV_W-1:0] div_last(input logic [1:0] code);
        case (code)
            2'd0:    div_last = DIV_W'(1);
            2'd1:    div_last = DIV_W'(2);
            2'd2:    div_last = DIV_W'(4);
            default: div_last = DIV_W'(5);
        endcase
    endfunction

endpackage

// File: rtl/pwmgen_tick_mux.sv
module pwmgen_tick_mux
    import pwmgen_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC-1:0] ticks,
    input  logic [1:0]       sel,
    output logic             tick_sel
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_hit
        assign hit[g] = ticks[g] & (sel == 2'(g + 1));
    end

    assign tick_sel = |hit;
endmodule

// File: rtl/pwmgen_divider.sv
module pwmgen_divider
    import pwmgen_pkg::*;
#(
    parameter int EW = EXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tick,
    input  logic [1:0]    div_code,
    input  logic [EW-1:0] exp_m,
    output logic          pre_pulse,
    output logic          step
);
    localparam int MAX_EXP = (1 << EW) - 1;
    localparam int ECW     = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] pre_lim;
    logic [ECW-1:0]   exp_cnt;
    logic [ECW-1:0]   exp_lim;
    logic             pre_end;
    logic             exp_end;

    assign pre_lim   = div_last(div_code);
    assign exp_lim   = ECW'((1 << exp_m) - 1);
    assign pre_end   = (pre_cnt >= pre_lim);
    assign exp_end   = (exp_cnt >= exp_lim);
    assign pre_pulse = active & tick & pre_end;
    assign step      = pre_pulse & exp_end;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pre_cnt <= '0;
            exp_cnt <= '0;
        end else if (tick) begin
            if (pre_end) begin
                pre_cnt <= '0;
                exp_cnt <= exp_end ? '0 : exp_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmgen_counter.sv
module pwmgen_counter
    import pwmgen_pkg::*;
#(
    parameter int WW = WIDE_W,
    parameter int NW = NARROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          step,
    input  logic          wide,
    input  logic [WW-1:0] duty,
    output logic [WW-1:0] res_cnt,
    output logic [WW-1:0] duty_q,
    output logic          wrap,
    output logic          pwm_out
);
    localparam logic [WW-1:0] WIDE_LIM   = {WW{1'b1}};
    localparam logic [WW-1:0] NARROW_LIM = WW'((1 << NW) - 1);

    logic [WW-1:0] lim;
    logic [WW-1:0] duty_eff;

    assign lim      = wide ? WIDE_LIM : NARROW_LIM;
    assign duty_eff = duty & lim;
    assign wrap     = step & (res_cnt >= lim);
    assign pwm_out  = active & (res_cnt < duty_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_cnt <= '0;
            duty_q  <= '0;
        end else if (!active) begin
            res_cnt <= '0;
            duty_q  <= duty_eff;
        end else if (step) begin
            if (wrap) begin
                res_cnt <= '0;
                duty_q  <= duty_eff;
            end else begin
                res_cnt <= res_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
    import pwmgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_slow,
    input  logic       tick_mid,
    input  logic       tick_fast,
    input  logic [1:0] src_sel,
    input  logic [1:0] div_code,
    input  logic [2:0] exp_m,
    input  logic       wide_mode,
    input  logic [7:0] duty_lsbs,
    input  logic       duty_msb,
    input  logic       out_en,
    input  logic       run_en,
    output logic       pwm_out
);
    logic              active;
    logic              tick_sel;
    logic              pre_pulse;
    logic              step;
    logic              wrap;
    logic [WIDE_W-1:0] res_cnt;
    logic [WIDE_W-1:0] duty_q;
    logic [WIDE_W-1:0] duty_full;

    assign active    = out_en & run_en & (src_e'(src_sel) != SRC_NONE);
    assign duty_full = {duty_msb, duty_lsbs};

    pwmgen_tick_mux #(.N_SRC(NUM_SRC)) u_mux (
        .ticks    ({tick_fast, tick_mid, tick_slow}),
        .sel      (src_sel),
        .tick_sel (tick_sel)
    );

    pwmgen_divider #(.EW(EXP_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .tick      (tick_sel),
        .div_code  (div_code),
        .exp_m     (exp_m),
        .pre_pulse (pre_pulse),
        .step      (step)
    );

    pwmgen_counter #(.WW(WIDE_W), .NW(NARROW_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .step    (step),
        .wide    (wide_mode),
        .duty    (duty_full),
        .res_cnt (res_cnt),
        .duty_q  (duty_q),
        .wrap    (wrap),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwmgen_chk.sv
module pwmgen_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_slow,
    input logic       tick_mid,
    input logic       tick_fast,
    input logic [1:0] src_sel,
    input logic       out_en,
    input logic       run_en,
    input logic       pwm_out,
    input logic       active,
    input logic       pre_pulse,
    input logic       step,
    input logic       wrap,
    input logic [8:0] res_cnt,
    input logic [8:0] duty_q
);
    logic chosen_tick;
    always_comb begin
        case (src_sel)
            2'd1:    chosen_tick = tick_slow;
            2'd2:    chosen_tick = tick_mid;
            2'd3:    chosen_tick = tick_fast;
            default: chosen_tick = 1'b0;
        endcase
    end

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !(out_en && run_en) |-> !pwm_out);

    assert_nosrc_low_R9: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'd0) |-> !pwm_out);

    assert_step_gated_R1: assert property (@(posedge clk) disable iff (rst)
        step |-> pre_pulse);

    assert_pulse_tick_R2: assert property (@(posedge clk) disable iff (rst)
        pre_pulse |-> chosen_tick);

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(step)) |-> (res_cnt == $past(res_cnt)));

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(wrap)) |-> (duty_q == $past(duty_q)));

    assert_zero_low_R6: assert property (@(posedge clk) disable iff (rst)
        (duty_q == 9'd0) |-> !pwm_out);

    assert_reset_low_R10: assert property (@(posedge clk)
        rst |=> (rst -> !pwm_out));
endmodule

bind pwmgen_top pwmgen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_slow (tick_slow),
    .tick_mid  (tick_mid),
    .tick_fast (tick_fast),
    .src_sel   (src_sel),
    .out_en    (out_en),
    .run_en    (run_en),
    .pwm_out   (pwm_out),
    .active    (active),
    .pre_pulse (pre_pulse),
    .step      (step),
    .wrap      (wrap),
    .res_cnt   (res_cnt),
    .duty_q    (duty_q)
);

// File: tb/sim_pwmgen_top.sv
`timescale 1ns/1ps
module sim_pwmgen_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_slow = 1'b0;
    logic       tick_mid = 1'b0;
    logic       tick_fast = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] div_code = 2'd0;
    logic [2:0] exp_m = 3'd0;
    logic       wide_mode = 1'b0;
    logic [7:0] duty_lsbs = 8'd0;
    logic       duty_msb = 1'b0;
    logic       out_en = 1'b0;
    logic       run_en = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwmgen_top u0 (
        .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_mid(tick_mid),
        .tick_fast(tick_fast), .src_sel(src_sel), .div_code(div_code),
        .exp_m(exp_m), .wide_mode(wide_mode), .duty_lsbs(duty_lsbs),
        .duty_msb(duty_msb), .out_en(out_en), .run_en(run_en), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Configure with the channel idle, let the duty be captured, then enable.
    task automatic start(input int src, input int dc, input int m, input bit w,
                         input int duty);
        @(negedge clk);
        out_en = 1'b0; run_en = 1'b0;
        src_sel = 2'(src); div_code = 2'(dc); exp_m = 3'(m); wide_mode = w;
        duty_lsbs = 8'(duty); duty_msb = duty[8];
        @(negedge clk);
        @(negedge clk);
        out_en = 1'b1; run_en = 1'b1;
    endtask

    // Count high samples over len cycles. The selected source ticks every k
    // cycles, starting with the first sample. The other sources tick every cycle.
    task automatic measure(input int k, input int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            tick_slow = (src_sel == 2'd1) ? (i % k == 0) : 1'b1;
            tick_mid  = (src_sel == 2'd2) ? (i % k == 0) : 1'b1;
            tick_fast = (src_sel == 2'd3) ? (i % k == 0) : 1'b1;
            #1;
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int hi;
        @(negedge clk);
        src_sel = 2'd3; duty_lsbs = 8'd20; out_en = 1'b1; run_en = 1'b1;
        measure(1, 4, hi);
        check("R10 output low in reset", hi, 0);
        out_en = 1'b0; run_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_basic;
        int hi;
        start(3, 0, 0, 1'b0, 16);
        measure(1, 128, hi);
        check("R1 R6 6-bit duty 16 D=2", hi, 32);
        measure(1, 128, hi);
        check("R1 second period repeats", hi, 32);
        start(3, 0, 0, 1'b0, 63);
        measure(1, 128, hi);
        check("R6 max 6-bit duty", hi, 126);
    endtask

    task automatic t_zero;
        int hi;
        start(3, 0, 0, 1'b0, 0);
        measure(1, 256, hi);
        check("R6 zero duty stays low", hi, 0);
    endtask

    task automatic t_wide;
        int hi;
        start(3, 0, 0, 1'b1, 300);
        measure(1, 1024, hi);
        check("R5 9-bit duty 300", hi, 600);
        start(3, 0, 0, 1'b0, 256 + 8'hC5);
        measure(1, 128, hi);
        check("R5 6-bit ignores bits 8..6", hi, 10);
    endtask

    task automatic t_prescale;
        int hi;
        start(3, 2, 2, 1'b0, 10);
        measure(1, 1280, hi);
        check("R3 R4 D=5 m=2", hi, 200);
        start(3, 1, 0, 1'b0, 7);
        measure(1, 192, hi);
        check("R3 D=3 m=0", hi, 21);
        start(3, 3, 7, 1'b0, 1);
        measure(1, 49152, hi);
        check("R3 R4 D=6 m=7", hi, 768);
    endtask

    task automatic t_sources;
        int hi;
        start(2, 1, 1, 1'b0, 20);
        measure(3, 1152, hi);
        check("R2 mid source every 3 cycles", hi, 360);
        start(1, 0, 0, 1'b0, 5);
        measure(2, 256, hi);
        check("R2 slow source every 2 cycles", hi, 20);
    endtask

    task automatic t_nosrc;
        int hi;
        start(0, 0, 0, 1'b0, 40);
        measure(1, 200, hi);
        check("R9 code 0 output low", hi, 0);
    endtask

    task automatic t_enables;
        int hi;
        start(3, 0, 0, 1'b0, 40);
        measure(1, 30, hi);
        check("R8 partial period before disable", hi, 30);
        out_en = 1'b0;
        measure(1, 5, hi);
        check("R8 out_en low gives low output", hi, 0);
        out_en = 1'b1; run_en = 1'b0;
        measure(1, 5, hi);
        check("R8 run_en low gives low output", hi, 0);
        run_en = 1'b1;
        measure(1, 128, hi);
        check("R8 restart from count zero", hi, 80);
    endtask

    task automatic t_boundary;
        int hi1;
        int hi2;
        int hi3;
        start(3, 0, 0, 1'b0, 8);
        measure(1, 64, hi1);
        duty_lsbs = 8'd40;
        measure(1, 64, hi2);
        check("R7 duty change waits for boundary", hi1 + hi2, 16);
        measure(1, 128, hi3);
        check("R7 new duty after boundary", hi3, 80);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_zero();
        t_wide();
        t_prescale();
        t_sources();
        t_nosrc();
        t_enables();
        t_boundary();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #950000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule